// File: doc/BRIEF.md
# Subset Load/Store Instruction Executor

This block executes one 32-bit instruction per enabled clock edge from a small integer subset: register add, register subtract, word load, word store, byte load and byte store. An instruction word is presented on `instr_in` together with `step_en`. In the same cycle the block decodes the word and reads two source registers from a 32-entry register file. It then either computes the arithmetic result or forms the effective address as a base register plus a sign-extended 16-bit offset. Any register write, and the program-counter update, takes effect at the closing clock edge.

Data memory sits outside the block and is byte addressed. The block drives a word-aligned address with per-byte write strobes. Lane 3 is `mem_wdata[31:23+1]` and holds the byte at offset 0, so memory is big-endian. The read word must return combinationally in the same cycle. For the instruction in flight, an illegal-instruction flag reports any opcode/function pair outside the subset. Such a word changes neither the register file nor memory.

Top module: `mexe_core`

## Requirements
- R1: After reset `pc_out` reads 0. It increases by 4 at each clock edge where `step_en` is high, illegal words included, and holds its value at every other edge.
- R2: Opcode 0 (bits 31:26) with function code 32 (bits 5:0) writes rs + rt, modulo 2^32, into rd. Register fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R3: Opcode 0 with function code 34 writes rs − rt, modulo 2^32, into rd.
- R4: Bits 10:6 of an add or subtract word have no effect on the result.
- R5: Opcode 35 loads the word at the effective address into rt, with address bits 1:0 cleared on `mem_addr`. `mem_rd_en` is high during that cycle and `mem_wr_en` is low.
- R6: Opcode 43 drives `mem_wr_en`, `mem_wstrb` = 4'b1111 and `mem_wdata` = rt.
- R7: The effective address is rs plus bits 15:0 sign-extended, so negative offsets address below the base.
- R8: Opcode 32 selects the byte at offset ea[1:0] from the read word, with offset 0 taken from bits 31:24. It writes that byte, sign-extended to 32 bits, into rt.
- R9: Opcode 40 drives exactly one strobe bit, bit 3 − ea[1:0], and places rt[7:0] in all four byte lanes of `mem_wdata`.
- R10: Register 0 always reads as zero, and writes to it are dropped.
- R11: Every other opcode, and opcode 0 with a function code other than 32 or 34, raises `illegal_out` for that cycle. No memory enable is driven and no register is written.
- R12: An instruction that reads and writes the same register uses the value from before the instruction for every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Execute `instr_in` at this clock edge |
| instr_in | input | 32 | Instruction word |
| pc_out | output | 32 | Program counter |
| illegal_out | output | 1 | Current word is outside the subset |
| mem_addr | output | 32 | Word-aligned data address |
| mem_rd_en | output | 1 | Load in progress this cycle |
| mem_wr_en | output | 1 | Store commits at this clock edge |
| mem_wstrb | output | 4 | Byte-lane write strobes, bit 3 = offset 0 |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read word at `mem_addr`, same cycle |

## Verification
In a single instruction the register file is read and written in the same cycle. It is also read for the store base and the store data at once. Writing `add` with rd equal to both sources provokes the first case, and the doubled value is later judged through a store. Writing a store whose base and data register coincide provokes the second case; its address and data on the memory port must both equal the register's old value. The stimulus also places a byte store and a word load of the same word on consecutive steps. The loaded word must show the merged byte in its correct lane.

// File: rtl/mexe_pkg.sv
package mexe_pkg;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_LDW   = 6'd35;
  localparam logic [5:0] OPC_STW   = 6'd43;
  localparam logic [5:0] OPC_LDB   = 6'd32;
  localparam logic [5:0] OPC_STB   = 6'd40;
  localparam logic [5:0] FN_ADD    = 6'd32;
  localparam logic [5:0] FN_SUB    = 6'd34;

  typedef enum logic [2:0] {
    OPK_ADD, OPK_SUB, OPK_LDW, OPK_STW, OPK_LDB, OPK_STB, OPK_BAD
  } opk_e;

  typedef struct packed {
    opk_e        kind;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [15:0] imm;
  } dec_t;

endpackage

// File: rtl/mexe_decode.sv
module mexe_decode
  import mexe_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    dec.rs   = instr[25:21];
    dec.rt   = instr[20:16];
    dec.rd   = instr[15:11];
    dec.imm  = instr[15:0];
    dec.kind = OPK_BAD;
    unique case (opc)
      OPC_REG: begin
        if (fn == FN_ADD)      dec.kind = OPK_ADD;
        else if (fn == FN_SUB) dec.kind = OPK_SUB;
      end
      OPC_LDW: dec.kind = OPK_LDW;
      OPC_STW: dec.kind = OPK_STW;
      OPC_LDB: dec.kind = OPK_LDB;
      OPC_STB: dec.kind = OPK_STB;
      default: dec.kind = OPK_BAD;
    endcase
  end

endmodule

// File: rtl/mexe_regfile.sv
module mexe_regfile #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  localparam int NENT = 1 << AW;

  // entry 0 has no storage: it reads as zero and absorbs writes
  logic [DW-1:0] ent_q [1:NENT-1];

  for (genvar i = 1; i < NENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (wa == AW'(i))) ent_q[i] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : ent_q[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : ent_q[ra_b];

endmodule

// File: rtl/mexe_lsu.sv
module mexe_lsu
  import mexe_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_sn,
  input  logic            active,
  input  opk_e            kind,
  input  logic [DW-1:0]   base,
  input  logic [15:0]     imm,
  input  logic [DW-1:0]   store_val,
  input  logic [DW-1:0]   rdata,
  output logic [DW-1:0]   addr,
  output logic [DW/8-1:0] wstrb,
  output logic [DW-1:0]   wdata,
  output logic [DW-1:0]   load_val
);

  localparam int NLANE = DW / 8;
  localparam int OFFW  = $clog2(NLANE);

  logic [DW-1:0]   ea;
  logic [OFFW-1:0] off;
  logic [OFFW-1:0] lane;
  logic [7:0]      byte_sel;

  assign ea       = base + {{(DW-16){imm[15]}}, imm};
  assign off      = ea[OFFW-1:0];
  assign lane     = OFFW'(NLANE - 1) - off;
  assign addr     = {ea[DW-1:OFFW], {OFFW{1'b0}}};
  assign byte_sel = rdata[{lane, 3'b000} +: 8];

  always_comb begin
    wstrb = '0;
    wdata = store_val;
    if (kind == OPK_STW) begin
      wstrb = '1;
    end else if (kind == OPK_STB) begin
      wstrb = NLANE'(1) << lane;
      wdata = {NLANE{store_val[7:0]}};
    end
  end

  assign load_val = (kind == OPK_LDB) ? {{(DW-8){byte_sel[7]}}, byte_sel} : rdata;

  AST_BYTE_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (active && kind == OPK_STB) |-> ($countones(wstrb) == 1)); // R9

endmodule

// File: rtl/mexe_core.sv
module mexe_core
  import mexe_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [31:0]   instr_in,
  output logic [DW-1:0] pc_out,
  output logic          illegal_out,
  output logic [DW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [DW/8-1:0] mem_wstrb,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int NLANE = DW / 8;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  dec_t dec;
  mexe_decode u_dec (.instr(instr_in), .dec(dec));

  logic [DW-1:0] src_a, src_b;
  logic          rf_we;
  logic [AW-1:0] rf_wa;
  logic [DW-1:0] rf_wd;
  logic [DW-1:0] ld_val;
  logic          is_load, is_store, is_alu;

  assign is_load  = (dec.kind == OPK_LDW) || (dec.kind == OPK_LDB);
  assign is_store = (dec.kind == OPK_STW) || (dec.kind == OPK_STB);
  assign is_alu   = (dec.kind == OPK_ADD) || (dec.kind == OPK_SUB);

  mexe_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk  (clk),
    .ra_a (dec.rs[AW-1:0]),
    .ra_b (dec.rt[AW-1:0]),
    .rd_a (src_a),
    .rd_b (src_b),
    .we   (rf_we),
    .wa   (rf_wa),
    .wd   (rf_wd)
  );

  mexe_lsu #(.DW(DW)) u_lsu (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .active    (step_en),
    .kind      (dec.kind),
    .base      (src_a),
    .imm       (dec.imm),
    .store_val (src_b),
    .rdata     (mem_rdata),
    .addr      (mem_addr),
    .wstrb     (mem_wstrb),
    .wdata     (mem_wdata),
    .load_val  (ld_val)
  );

  // writeback selection
  always_comb begin
    rf_we = step_en && rst_sn && (is_alu || is_load);
    rf_wa = is_load ? dec.rt[AW-1:0] : dec.rd[AW-1:0];
    unique case (dec.kind)
      OPK_ADD: rf_wd = src_a + src_b;
      OPK_SUB: rf_wd = src_a - src_b;
      default: rf_wd = ld_val;
    endcase
  end

  assign mem_rd_en   = step_en && is_load;
  assign mem_wr_en   = step_en && is_store;
  assign illegal_out = step_en && (dec.kind == OPK_BAD);

  // program counter
  logic [DW-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (step_en) pc_d = pc_q + DW'(4);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_out = pc_q;

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sn)
    step_en |=> (pc_out == $past(pc_out) + DW'(4))); // R1

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !step_en |=> $stable(pc_out)); // R1

  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_sn)
    illegal_out |-> (!mem_wr_en && !mem_rd_en && !rf_we)); // R11

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_rd_en && mem_wr_en)); // R5

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_wr_en |-> !rf_we); // R6

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_sn)
    !mem_wr_en |-> (mem_wstrb == '0)); // R6

  localparam int UNUSED_LANES = NLANE;

endmodule

// File: tb/sim_mexe_core.sv
`timescale 1ns/1ps
module sim_mexe_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en;
  logic [31:0] instr_in;
  logic [31:0] pc_out;
  logic        illegal_out;
  logic [31:0] mem_addr;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic [3:0]  mem_wstrb;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;
  int nsteps = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mexe_core u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr_in(instr_in),
    .pc_out(pc_out), .illegal_out(illegal_out), .mem_addr(mem_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // data memory model, big-endian lanes
  logic [31:0] dmem [0:31];
  assign mem_rdata = dmem[mem_addr[6:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) dmem[i] <= 32'h0;
      dmem[0] <= 32'h0000_0005;
      dmem[1] <= 32'h0000_0007;
      dmem[2] <= 32'h8012_A47F;
    end else if (mem_wr_en) begin
      for (int k = 0; k < 4; k++)
        if (mem_wstrb[k]) dmem[mem_addr[6:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    end
  end

  typedef struct {
    logic [31:0] a;
    logic [3:0]  s;
    logic [31:0] d;
    string       tag;
  } wr_item_t;

  wr_item_t exp_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: every store seen on the port must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected store", mem_addr, 32'h0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(mem_addr == it.a, {it.tag, " addr"}, mem_addr, it.a);
        check(mem_wstrb == it.s, {it.tag, " strobe"}, {28'h0, mem_wstrb}, {28'h0, it.s});
        check(mem_wdata == it.d, {it.tag, " data"}, mem_wdata, it.d);
      end
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic step(input logic [31:0] ins);
    @(posedge clk); #1;
    instr_in = ins;
    step_en  = 1'b1;
    nsteps++;
    #1;
  endtask

  task automatic store(input logic [31:0] ins, input logic [31:0] a, input logic [3:0] s,
                       input logic [31:0] d, input string tag);
    wr_item_t it;
    it.a = a; it.s = s; it.d = d; it.tag = tag;
    exp_q.push_back(it);
    step(ins);
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    step_en = 1'b0;
    instr_in = 32'h0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    step_en = 1'b0;
    instr_in = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(pc_out == 32'h0, "R1 reset pc", pc_out, 32'h0);
    check(!mem_wr_en && !mem_rd_en && !illegal_out, "R1 idle outputs",
          {29'h0, mem_wr_en, mem_rd_en, illegal_out}, 32'h0);

    step(enc_i(35, 0, 1, 0));                       // r1 = 5
    check(mem_rd_en && !mem_wr_en, "R5 read enable", {31'h0, mem_rd_en}, 32'h1);
    check(mem_addr == 32'h0, "R5 address", mem_addr, 32'h0);
    step(enc_i(35, 0, 2, 4));                       // r2 = 7
    check(pc_out == 32'h4, "R1 pc after one step", pc_out, 32'h4);
    step(enc_r(1, 2, 3, 0, 32));                    // r3 = 12
    store(enc_i(43, 0, 3, 32), 32'd32, 4'hF, 32'd12, "R2 add");
    step(enc_r(1, 2, 4, 0, 34));                    // r4 = -2
    store(enc_i(43, 0, 4, 36), 32'd36, 4'hF, 32'hFFFF_FFFE, "R3 sub wrap");
    step(enc_r(1, 1, 5, 31, 32));                   // shamt field set, r5 = 10
    store(enc_i(43, 0, 5, 40), 32'd40, 4'hF, 32'd10, "R4 shamt ignored");

    step(enc_i(35, 3, 6, -4));                      // ea = 12-4 = 8
    check(mem_addr == 32'd8, "R7 negative offset address", mem_addr, 32'd8);
    store(enc_i(43, 3, 6, 32), 32'd44, 4'hF, 32'h8012_A47F, "R7 load via negative offset");

    step(enc_i(32, 3, 7, -3));                      // ea = 9, byte 0x12
    store(enc_i(43, 0, 7, 48), 32'd48, 4'hF, 32'h0000_0012, "R8 byte positive");
    step(enc_i(32, 0, 8, 10));                      // ea = 10, byte 0xA4
    store(enc_i(43, 0, 8, 52), 32'd52, 4'hF, 32'hFFFF_FFA4, "R8 byte sign-extended");

    store(enc_i(40, 0, 1, 57), 32'd56, 4'b0100, 32'h0505_0505, "R9 byte store");
    step(enc_i(35, 0, 10, 56));
    store(enc_i(43, 0, 10, 60), 32'd60, 4'hF, 32'h0005_0000, "R9 byte merged lane");

    step(enc_r(1, 2, 0, 0, 32));                    // write to r0 dropped
    store(enc_i(43, 0, 0, 64), 32'd64, 4'hF, 32'h0, "R10 zero register");

    step(enc_r(1, 2, 3, 0, 33));                    // bad funct aimed at r3
    check(illegal_out == 1'b1, "R11 bad funct flag", {31'h0, illegal_out}, 32'h1);
    check(!mem_wr_en && !mem_rd_en, "R11 bad funct no mem", {30'h0, mem_wr_en, mem_rd_en}, 32'h0);
    step(enc_i(9, 0, 1, 68));                       // bad opcode aimed at r1
    check(illegal_out == 1'b1, "R11 bad opcode flag", {31'h0, illegal_out}, 32'h1);
    check(!mem_wr_en && !mem_rd_en, "R11 bad opcode no mem", {30'h0, mem_wr_en, mem_rd_en}, 32'h0);
    store(enc_i(43, 0, 3, 68), 32'd68, 4'hF, 32'd12, "R11 r3 untouched");
    check(illegal_out == 1'b0, "R11 flag clears", {31'h0, illegal_out}, 32'h0);
    store(enc_i(43, 0, 1, 72), 32'd72, 4'hF, 32'd5, "R11 r1 untouched");

    step(enc_r(2, 2, 2, 0, 32));                    // r2 = 7+7
    store(enc_i(43, 0, 2, 76), 32'd76, 4'hF, 32'd14, "R12 same source and dest");
    store(enc_i(43, 3, 3, 0), 32'd12, 4'hF, 32'd12, "R12 base equals data");

    idle(3);
    check(pc_out == 32'(4 * nsteps), "R1 pc total and hold", pc_out, 32'(4 * nsteps));
    idle(2);
    check(pc_out == 32'(4 * nsteps), "R1 pc holds when idle", pc_out, 32'(4 * nsteps));
    check(exp_q.size() == 0, "R6 all stores seen", 32'(exp_q.size()), 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule